// File: doc/BRIEF.md
# SPI Flash Register Sequencer

This block carries out one register-level transaction with a serial flash device: reading a status or identification register, setting the write latch, programming a page or starting an erase. One 32-bit request word describes the whole transaction. The word holds the command byte, the number of address bytes, the number of bytes to write and the number of bytes to read back, plus a flag that marks the transaction as a write. The host sets the request word, the address bytes, the write payload and a gap length, then pulses `start`. The block drives chip select, the serial clock and the data-in line, samples the data-out line and finishes with a one-cycle `done` pulse.

The serial clock runs at half the system clock in SPI mode 0. The command, address and write data go out MSB first. A read transaction then stops the clock, releases the data-in line and holds the clock low for a programmable number of extra system cycles. Only then does it clock the read bytes in. Up to eight read bytes are packed into a 64-bit result, starting at the least significant byte. The result is cleared each time a new request is accepted.

Top module: `sfreg_seq`

## Requirements
- R1: The command is `req_word[23:16]`. The address byte count is `req_word[7:4]`, clamped to 4. The write byte count is `req_word[11:8]`, clamped to 8. The block sends the command, then the selected low bytes of `req_addr` (highest selected byte first), then the write bytes starting at `req_wdata[7:0]` and moving upward. Every byte goes out MSB first.
- R2: The transmit phase gives exactly 8 + 8·(address count) + 8·(write count) clock pulses. A count of zero removes its phase entirely.
- R3: When `req_word[30]` is 0, the read byte count is `req_word[15:12]`, clamped to 8, and the read phase gives 8 clock pulses per byte. Received byte k is placed in `result[8k+7:8k]`, with its first bit in the most significant position. Bytes that are not read stay zero.
- R4: When `req_word[30]` is 1, the transaction is a write. There is no read phase whatever the read count, and the data-in line stays driven until chip select rises. A read transaction with a read count of zero ends straight after the transmit phase.
- R5: Before a read phase, the data-in line is released after the last transmit pulse. The clock stays low for one system cycle plus `gap_len` system cycles before the first read pulse.
- R6: While chip select is low, each clock pulse is high for one system cycle and low for at least one. Data-in changes only while the clock is low, and data-out is sampled at the rising edge.
- R7: `result` reads zero in the cycle after a request is accepted.
- R8: Chip select rises only while the clock is low, and the clock is low whenever chip select is high. `done` is high for exactly one cycle, the cycle in which chip select has just risen.
- R9: A `start` pulse while `busy` is high has no effect on the running transaction and does not queue a new one. A `start` in the cycle where `done` is high is accepted.
- R10: After reset, chip select is high, the clock is low, data-in is released, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept the request when idle |
| req_word | input | 32 | Transaction descriptor |
| req_addr | input | 32 | Address bytes, the low ones are used |
| req_wdata | input | 64 | Write payload, byte 0 first |
| gap_len | input | 4 | Extra low-clock cycles before the read phase |
| spi_do | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_clk | output | 1 | Serial clock |
| spi_di | output | 1 | Serial data to the flash |
| spi_di_oe | output | 1 | Output enable of the data-in line |
| busy | output | 1 | A transaction is running |
| done | output | 1 | One-cycle end-of-transaction pulse |
| result | output | 64 | Packed read bytes |

## Verification
The end of one transaction and the acceptance of the next can fall in the same cycle. In the cycle where `done` is high the sequencer is already idle, so a `start` held there must be taken, and the next cycle must show a busy block with the result cleared. The bench drives `start` in exactly that done cycle after an identification read. It then checks that the old result was visible during `done`, that the new request is running with a zero result one cycle later, and that the second read returns its own byte. A second case overlaps `start` with a running transaction and checks that the counts, the bits and the result match a run with no disturbance.

// File: rtl/sfreg_pkg.sv
// Shared types of the SPI flash register sequencer.
// Assumes: a single sequencer state machine uses these encodings.
package sfreg_pkg;

    // Phases of one register transaction
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_TX   = 3'd1,
        ST_GAP  = 3'd2,
        ST_RX   = 3'd3,
        ST_END  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/sfreg_decode.sv
// Request decoder: extracts the command and the clamped phase lengths
// from the packed descriptor word and converts them to clock counts.
// Assumes: the limits fit in a 4-bit nibble field.
module sfreg_decode #(
    parameter int ADDR_MAX = 4,
    parameter int WR_MAX   = 8,
    parameter int RD_MAX   = 8,
    parameter int CNT_W    = 7
) (
    input  logic [31:0]      req_word,
    output logic [7:0]       cmd,
    output logic [3:0]       n_addr,
    output logic             is_write,
    output logic [CNT_W-1:0] tx_bits,
    output logic [CNT_W-1:0] rx_bits
);

    logic [3:0] f_addr, f_wr, f_rd;
    logic [3:0] n_wr, n_rd;
    logic       unused_bits;

    assign f_addr      = req_word[7:4];
    assign f_wr        = req_word[11:8];
    assign f_rd        = req_word[15:12];
    assign cmd         = req_word[23:16];
    assign is_write    = req_word[30];
    assign unused_bits = ^{req_word[31], req_word[29:24], req_word[3:0]};

    // Clamp each byte count and form the clock counts of both phases
    always_comb begin
        n_addr  = (f_addr > 4'(ADDR_MAX)) ? 4'(ADDR_MAX) : f_addr;
        n_wr    = (f_wr   > 4'(WR_MAX))   ? 4'(WR_MAX)   : f_wr;
        n_rd    = (f_rd   > 4'(RD_MAX))   ? 4'(RD_MAX)   : f_rd;
        tx_bits = CNT_W'(8 + 8 * int'(n_addr) + 8 * int'(n_wr));
        rx_bits = is_write ? '0 : CNT_W'(8 * int'(n_rd));
    end

endmodule

// File: rtl/sfreg_txpath.sv
// Transmit shifter: builds one left-aligned vector of command, address
// and write bytes at load time and shifts it out MSB first.
// Assumes: the sequencer stops shifting after the counted bits, so
// bytes past the requested lengths are never put on the line.
module sfreg_txpath #(
    parameter int ADDR_MAX = 4,
    parameter int WR_MAX   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  shift,
    input  logic [7:0]            cmd,
    input  logic [3:0]            n_addr,
    input  logic [8*ADDR_MAX-1:0] addr,
    input  logic [8*WR_MAX-1:0]   wdata,
    output logic                  di
);

    localparam int A_W   = 8 * ADDR_MAX;
    localparam int D_W   = 8 * WR_MAX;
    localparam int VEC_W = 8 + A_W + D_W;

    logic [D_W-1:0]   wrev;
    logic [A_W-1:0]   addr_al;
    logic [VEC_W-1:0] load_vec;
    logic [VEC_W-1:0] vec_q;

    // Reverse byte order so payload byte 0 leads
    for (genvar g = 0; g < WR_MAX; g++) begin : g_rev
        assign wrev[D_W-1-8*g -: 8] = wdata[8*g +: 8];
    end

    // Left-align the selected address bytes and splice the payload after them
    always_comb begin
        addr_al  = addr << (8 * (ADDR_MAX - int'(n_addr)));
        load_vec = {cmd, addr_al, {D_W{1'b0}}}
                 | ({wrev, {(8 + A_W){1'b0}}} >> (8 + 8 * int'(n_addr)));
    end

    // Hold and shift the outgoing bit stream
    always_ff @(posedge clk) begin
        if (!rst_n)     vec_q <= '0;
        else if (load)  vec_q <= load_vec;
        else if (shift) vec_q <= {vec_q[VEC_W-2:0], 1'b0};
    end

    assign di = vec_q[VEC_W-1];

endmodule

// File: rtl/sfreg_rxpack.sv
// Receive packer: places each sampled bit into the result register,
// byte 0 first, with the first bit of a byte in its MSB.
// Assumes: clear and capture are never high together.
module sfreg_rxpack #(
    parameter int RD_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                capture,
    input  logic                bit_in,
    output logic [8*RD_MAX-1:0] result
);

    localparam int RES_W = 8 * RD_MAX;
    localparam int IDX_W = $clog2(RES_W + 1);
    localparam int POS_W = $clog2(RES_W);

    logic [IDX_W-1:0] idx_q;
    logic [POS_W-1:0] pos;

    assign pos = POS_W'({idx_q[IDX_W-1:3], ~idx_q[2:0]});

    // Clear on a new request, otherwise pack one sampled bit per capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            idx_q  <= '0;
        end else if (clear) begin
            result <= '0;
            idx_q  <= '0;
        end else if (capture) begin
            result[pos] <= bit_in;
            idx_q       <= idx_q + IDX_W'(1);
        end
    end

    assert_rx_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (idx_q < IDX_W'(RES_W)));

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (result == '0));

endmodule

// File: rtl/sfreg_seq.sv
// SPI flash register sequencer top: accepts one descriptor, runs the
// transmit, gap and receive phases with a half-rate mode-0 clock and
// raises done as chip select returns high.
// Assumes: gap_len and the request inputs are held stable only at start.
module sfreg_seq
    import sfreg_pkg::*;
#(
    parameter int ADDR_MAX = 4,
    parameter int WR_MAX   = 8,
    parameter int RD_MAX   = 8,
    parameter int GAP_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [31:0]           req_word,
    input  logic [8*ADDR_MAX-1:0] req_addr,
    input  logic [8*WR_MAX-1:0]   req_wdata,
    input  logic [GAP_W-1:0]      gap_len,
    input  logic                  spi_do,
    output logic                  spi_cs_n,
    output logic                  spi_clk,
    output logic                  spi_di,
    output logic                  spi_di_oe,
    output logic                  busy,
    output logic                  done,
    output logic [8*RD_MAX-1:0]   result
);

    localparam int TX_MAX_BITS = 8 * (1 + ADDR_MAX + WR_MAX);
    localparam int CNT_W       = $clog2(TX_MAX_BITS + 1);

    seq_state_t       state_q;
    logic             sclk_q, cs_n_q, oe_q, done_q, wr_q;
    logic [CNT_W-1:0] cnt_q, rxb_q;
    logic [GAP_W-1:0] gcnt_q, gap_q;

    logic [7:0]       dec_cmd;
    logic [3:0]       dec_naddr;
    logic             dec_write;
    logic [CNT_W-1:0] dec_tx, dec_rx;
    logic             accept, tx_shift, rx_capture;

    sfreg_decode #(
        .ADDR_MAX(ADDR_MAX), .WR_MAX(WR_MAX), .RD_MAX(RD_MAX), .CNT_W(CNT_W)
    ) u_decode (
        .req_word (req_word),
        .cmd      (dec_cmd),
        .n_addr   (dec_naddr),
        .is_write (dec_write),
        .tx_bits  (dec_tx),
        .rx_bits  (dec_rx)
    );

    assign accept     = start && (state_q == ST_IDLE);
    assign tx_shift   = (state_q == ST_TX) && sclk_q;
    assign rx_capture = (state_q == ST_RX) && !sclk_q;

    sfreg_txpath #(.ADDR_MAX(ADDR_MAX), .WR_MAX(WR_MAX)) u_txpath (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .shift  (tx_shift),
        .cmd    (dec_cmd),
        .n_addr (dec_naddr),
        .addr   (req_addr),
        .wdata  (req_wdata),
        .di     (spi_di)
    );

    sfreg_rxpack #(.RD_MAX(RD_MAX)) u_rxpack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (rx_capture),
        .bit_in  (spi_do),
        .result  (result)
    );

    // Phase sequencing, clock generation and chip-select control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sclk_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
            cnt_q   <= '0;
            rxb_q   <= '0;
            gcnt_q  <= '0;
            gap_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_TX;
                        cs_n_q  <= 1'b0;
                        oe_q    <= 1'b1;
                        cnt_q   <= dec_tx;
                        rxb_q   <= dec_rx;
                        gap_q   <= gap_len;
                        wr_q    <= dec_write;
                    end
                end
                ST_TX: begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        cnt_q  <= cnt_q - CNT_W'(1);
                        if (cnt_q == CNT_W'(1)) begin
                            if (rxb_q != '0) begin
                                oe_q  <= 1'b0;
                                cnt_q <= rxb_q;
                                if (gap_q == '0) begin
                                    state_q <= ST_RX;
                                end else begin
                                    state_q <= ST_GAP;
                                    gcnt_q  <= gap_q;
                                end
                            end else begin
                                state_q <= ST_END;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (gcnt_q <= GAP_W'(1)) state_q <= ST_RX;
                    else                     gcnt_q  <= gcnt_q - GAP_W'(1);
                end
                ST_RX: begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        cnt_q  <= cnt_q - CNT_W'(1);
                        if (cnt_q == CNT_W'(1)) state_q <= ST_END;
                    end
                end
                ST_END: begin
                    cs_n_q  <= 1'b1;
                    oe_q    <= 1'b0;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign spi_cs_n  = cs_n_q;
    assign spi_clk   = sclk_q;
    assign spi_di_oe = oe_q;
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;

    assert_cs_rise_clk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> !sclk_q);

    assert_idle_clk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sclk_q);

    assert_done_on_cs_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $rose(cs_n_q));

    assert_clk_high_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_q && sclk_q) |=> !sclk_q);

    assert_write_drives_di_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_q && wr_q) |-> oe_q);

    assert_gap_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (!sclk_q && !oe_q));

endmodule

// File: tb/sfreg_seq_bench.sv
`timescale 1ns/1ps
module sfreg_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_word = '0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [3:0]  gap_len = '0;
    logic        spi_do = 1'b0;
    logic        spi_cs_n, spi_clk, spi_di, spi_di_oe, busy, done;
    logic [63:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sfreg_seq u_sfreg_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata), .gap_len(gap_len),
        .spi_do(spi_do), .spi_cs_n(spi_cs_n), .spi_clk(spi_clk),
        .spi_di(spi_di), .spi_di_oe(spi_di_oe), .busy(busy), .done(done),
        .result(result)
    );

    // Stimulus table: {word, addr, gap, wdata, flash reply, expected result}
    localparam int N = 11;
    localparam logic [263:0] TBL [N] = '{
        {32'h0005_1000, 32'h0,         8'd5, 64'h0,                 64'h0000_0000_0000_00A5, 64'h0000_0000_0000_00A5},
        {32'h009F_3000, 32'h0,         8'd5, 64'h0,                 64'h1122_3344_55EF_4018, 64'h0000_0000_00EF_4018},
        {32'h4006_0000, 32'h0,         8'd5, 64'h0,                 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {32'h4002_0430, 32'h0012_3456, 8'd5, 64'h0000_0000_DDCC_BBAA, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {32'h4020_0030, 32'h00AB_CDEF, 8'd5, 64'h0,                 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {32'h005A_C030, 32'h0000_1000, 8'd2, 64'h0,                 64'h0102_0304_0506_0708, 64'h0102_0304_0506_0708},
        {32'h0035_2000, 32'h0,         8'd0, 64'h0,                 64'h5566_7788_99AA_BBCC, 64'h0000_0000_0000_BBCC},
        {32'h4001_2100, 32'h0,         8'd5, 64'h0000_0000_0000_003C, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {32'h00B9_0000, 32'h0,         8'd5, 64'h0,                 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {32'h0003_1070, 32'h89AB_CDEF, 8'd1, 64'h0,                 64'h0000_0000_0000_007E, 64'h0000_0000_0000_007E},
        {32'h4002_F010, 32'h0000_0077, 8'd5, 64'h8877_6655_4433_2211, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0}
    };

    // Flash model: presents reply bits after the transmit clocks, changing on falling edges
    int          fall_cnt = 0;
    int          model_tx = 0;
    int          model_idx = 0;
    logic [63:0] model_resp = '0;
    always @(negedge spi_clk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            fall_cnt = 0;
            spi_do   = 1'b0;
        end else begin
            fall_cnt  = fall_cnt + 1;
            model_idx = fall_cnt - model_tx;
            if (model_idx >= 0 && model_idx < 64)
                spi_do = model_resp[8 * (model_idx / 8) + 7 - (model_idx % 8)];
            else
                spi_do = 1'b0;
        end
    end

    // Line monitor: counts pulses, captures sent bits, measures clock high and low runs
    int           tx_rises = 0, rx_rises = 0, rises = 0;
    int           lowrun = 0, highrun = 0, maxlow = 0, maxhigh = 0;
    logic [103:0] tx_cap = '0;
    logic         prev_clk = 1'b0;
    always @(negedge clk) begin
        if (start && !busy) begin
            tx_rises = 0; rx_rises = 0; rises = 0;
            lowrun = 0; highrun = 0; maxlow = 0; maxhigh = 0;
            tx_cap = '0;
        end else if (!spi_cs_n) begin
            if (spi_clk) begin
                if (!prev_clk) begin
                    if (spi_di_oe) begin
                        tx_rises = tx_rises + 1;
                        tx_cap   = {tx_cap[102:0], spi_di};
                    end else begin
                        rx_rises = rx_rises + 1;
                    end
                    if (rises > 0 && lowrun > maxlow) maxlow = lowrun;
                    rises   = rises + 1;
                    lowrun  = 0;
                    highrun = 0;
                end
                highrun = highrun + 1;
                if (highrun > maxhigh) maxhigh = highrun;
            end else begin
                lowrun = lowrun + 1;
            end
        end
        prev_clk = spi_clk;
    end

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin
                ok = 1'b1;
                return;
            end
        end
    endtask

    // One transaction: optional start poke while busy, optional chained start in the done cycle
    task automatic run_entry(input logic [263:0] e, input int poke_at, input bit chain);
        logic [31:0]  w     = e[263:232];
        logic [31:0]  addr  = e[231:200];
        logic [7:0]   gap   = e[199:192];
        logic [63:0]  wdata = e[191:128];
        logic [63:0]  resp  = e[127:64];
        logic [63:0]  expr  = e[63:0];
        logic [103:0] ec    = '0;
        int  na, nw, nr, etx, erx, elow;
        bit  isw, ok;
        na  = (int'(w[7:4])   > 4) ? 4 : int'(w[7:4]);
        nw  = (int'(w[11:8])  > 8) ? 8 : int'(w[11:8]);
        nr  = (int'(w[15:12]) > 8) ? 8 : int'(w[15:12]);
        isw = w[30];
        etx = 8 + 8 * na + 8 * nw;
        erx = isw ? 0 : 8 * nr;
        elow = (erx > 0) ? 1 + int'(gap) : 1;
        for (int b = 7; b >= 0; b--) ec = {ec[102:0], w[16 + b]};
        for (int j = na - 1; j >= 0; j--)
            for (int b = 7; b >= 0; b--) ec = {ec[102:0], addr[8 * j + b]};
        for (int j = 0; j < nw; j++)
            for (int b = 7; b >= 0; b--) ec = {ec[102:0], wdata[8 * j + b]};
        model_tx   = etx;
        model_resp = resp;
        @(posedge clk); #1;
        start = 1'b1; req_word = w; req_addr = addr; req_wdata = wdata; gap_len = gap[3:0];
        @(posedge clk); #1;
        start = 1'b0;
        if (poke_at > 0) begin
            repeat (poke_at) @(posedge clk);
            #1 start = 1'b1; req_word = 32'h4006_0000;
            @(posedge clk); #1 start = 1'b0;
        end
        wait_done(ok);
        chk("R8", "done pulse seen", 128'(ok), 128'd1);
        chk("R3", "result packing", 128'(result), 128'(expr));
        chk("R2", "transmit pulse count", 128'(tx_rises), 128'(etx));
        chk("R1", "transmit bit stream", 128'(tx_cap), 128'(ec));
        chk(isw ? "R4" : "R3", "read pulse count", 128'(rx_rises), 128'(erx));
        chk("R5", "longest clock low run", 128'(maxlow), 128'(elow));
        chk("R6", "longest clock high run", 128'(maxhigh), 128'd1);
        chk("R8", "chip select high at done", 128'(spi_cs_n), 128'd1);
        if (chain) begin
            start = 1'b1; req_word = 32'h0005_1000; gap_len = 4'd5;
            model_tx = 8; model_resp = 64'h5A;
        end else begin
            @(negedge clk);
            chk("R8", "done lasts one cycle", 128'(done), 128'd0);
        end
    endtask

    initial begin : watchdog
        #(100000 * 4);
        $display("FAIL R8 watchdog expired: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
        $finish;
    end

    initial begin : main
        bit ok;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "reset chip select", 128'(spi_cs_n), 128'd1);
        chk("R10", "reset clock", 128'(spi_clk), 128'd0);
        chk("R10", "reset data enable", 128'(spi_di_oe), 128'd0);
        chk("R10", "reset busy/done", 128'({busy, done}), 128'd0);
        chk("R10", "reset result", 128'(result), 128'd0);

        for (int i = 0; i < N; i++) run_entry(TBL[i], 0, 1'b0);

        // R9: a start while busy must leave the long read untouched
        run_entry(TBL[5], 10, 1'b0);
        repeat (20) @(negedge clk);
        chk("R9", "no queued request", 128'({busy, spi_cs_n}), 128'b01);

        // R9/R7: start in the done cycle is taken and clears the result
        run_entry(TBL[1], 0, 1'b1);
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk("R9", "chained start accepted", 128'({busy, spi_cs_n}), 128'b10);
        chk("R8", "done gone after chain", 128'(done), 128'd0);
        chk("R7", "result cleared on accept", 128'(result), 128'd0);
        wait_done(ok);
        chk("R3", "chained read result", 128'(result), 128'h5A);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule